// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block decides when a small processor and its peripherals receive clock, and which source drives them. A one-cycle sleep request, taken while the processor runs, moves the controller into an idle state or into sleep. In idle the processor clock stops and the peripherals keep running. In sleep both stop. A 2-bit clock select picks the source used in idle and after the wake. If the secondary oscillator is selected but not enabled, the source does not change.

An interrupt, a watchdog time-out or a device reset ends idle or sleep. The controller may first wait for a crystal-type primary oscillator to start, and then for its PLL to lock. It always waits a fixed delay before it flags the processor ready. Clocks are modelled as enables within one system clock. A one-cycle code reports why the wake happened. A reset exit also asks for a restart from address zero.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a sleep request is sampled in run with idle_en=1, the block enters idle: cpu_clk_en=0 and per_clk_en=1. With idle_en=0 it enters sleep: cpu_clk_en=0, per_clk_en=0 and clk_src=000.
- R2: clk_src is one-hot with bit0 for primary, bit1 for secondary and bit2 for internal, or 000 while no peripheral clock runs. clk_sel=00 selects primary and clk_sel=01 selects secondary. When clk_sel[1]=1 the block selects internal whatever clk_sel[0] is.
- R3: In idle or sleep, only int_pend, wdt_tmo or dev_rst cause an exit. A sleep request there has no effect, and the outputs hold their values.
- R4: After a wake, cpu_ready stays 0 for WAKE_DLY cycles (default 2), counted after any start-up wait. The processor then runs with cpu_clk_en=1 from the same source it had in idle.
- R5: If clk_sel=01 and sosc_en=0 when the sleep request is sampled, the source stays as it was.
- R6: Entering sleep clears osc_stable. Entering idle on the secondary or internal source also clears it. Entering primary idle leaves it unchanged.
- R7: A wake on the primary source while osc_stable=0 and pri_xtal=1 first waits OST_CYC cycles (default 1024). If pri_pll=1 it then waits PLL_CYC cycles (default 64). After that it sets osc_stable. Otherwise a wake on primary sets osc_stable and applies only WAKE_DLY. The cycle counts from the wake edge to the first sample with cpu_ready=1 are 1026, 1090 and 2.
- R8: wake_cause shows one cycle after the wake edge: 01 for an interrupt, 10 for a watchdog time-out and 11 for a reset. Reset beats watchdog, and watchdog beats interrupt.
- R9: dev_rst in any state, run included, starts the wake path with cause 11. pc_restart then pulses for one cycle, in the same cycle that cpu_ready rises.
- R10: After rst_n the block runs on primary: cpu_clk_en=1, per_clk_en=1, clk_src=001, osc_stable=1, cpu_ready=1, wake_cause=00 and pc_restart=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | One-cycle request to leave run |
| idle_en | input | 1 | 1 selects idle, 0 selects sleep |
| clk_sel | input | 2 | Source for idle and the following run |
| sosc_en | input | 1 | Secondary oscillator is enabled |
| pri_xtal | input | 1 | Primary source is crystal type and needs start-up |
| pri_pll | input | 1 | Primary source uses a PLL that must lock |
| int_pend | input | 1 | Interrupt pending |
| wdt_tmo | input | 1 | Watchdog time-out |
| dev_rst | input | 1 | Device reset request |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_src | output | 3 | One-hot active source |
| osc_stable | output | 1 | Primary oscillator running and stable |
| cpu_ready | output | 1 | Processor may execute |
| wake_cause | output | 2 | One-cycle wake reason |
| pc_restart | output | 1 | Restart at address zero |

## Verification
The bench selects the secondary source with its enable low. A design without the fallback would report secondary in clk_src. It wakes from primary idle with a crystal primary. A design that always ran the start-up count would need 1026 cycles where 2 are due. It also enters primary idle from internal run. A design that skipped the count there would be ready too early. It raises interrupt and watchdog together, and then all three wake sources together. A design with the wrong priority would report the wrong wake_cause. It times sleep exits with and without crystal and PLL, and applies a reset during run. A missing PLL wait, or a missing restart pulse, shows up as a wrong cycle count or an absent pc_restart.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int OST_CYC  = 1024,
  parameter int PLL_CYC  = 64,
  parameter int WAKE_DLY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       idle_en,
  input  logic [1:0] clk_sel,
  input  logic       sosc_en,
  input  logic       pri_xtal,
  input  logic       pri_pll,
  input  logic       int_pend,
  input  logic       wdt_tmo,
  input  logic       dev_rst,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [2:0] clk_src,
  output logic       osc_stable,
  output logic       cpu_ready,
  output logic [1:0] wake_cause,
  output logic       pc_restart
);
  localparam int MAX_A = (OST_CYC > PLL_CYC) ? OST_CYC : PLL_CYC;
  localparam int MAXC  = (MAX_A > WAKE_DLY) ? MAX_A : WAKE_DLY;
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_RUN = 3'd0, S_IDLE = 3'd1, S_SLEEP = 3'd2,
    S_OST = 3'd3, S_PLL = 3'd4, S_WDLY = 3'd5
  } st_t;

  st_t           state;
  logic [2:0]    src;
  logic [CW-1:0] cnt;
  logic          rst_seen;

  wire asleep   = (state == S_IDLE) || (state == S_SLEEP);
  wire wake     = dev_rst || (asleep && (int_pend || wdt_tmo));
  wire need_ost = src[0] && !osc_stable && pri_xtal;
  wire [2:0] sel_src = clk_sel[1] ? 3'b100 :
                       clk_sel[0] ? (sosc_en ? 3'b010 : src) : 3'b001;
  wire [1:0] cause   = dev_rst ? 2'b11 : wdt_tmo ? 2'b10 : 2'b01;

  assign cpu_clk_en = (state == S_RUN);
  assign cpu_ready  = (state == S_RUN);
  assign per_clk_en = (state == S_RUN) || (state == S_IDLE) || (state == S_WDLY);
  assign clk_src    = per_clk_en ? src : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_RUN;
      src        <= 3'b001;
      osc_stable <= 1'b1;
      cnt        <= '0;
      rst_seen   <= 1'b0;
      wake_cause <= 2'b00;
      pc_restart <= 1'b0;
    end else begin
      wake_cause <= 2'b00;
      pc_restart <= 1'b0;
      if (wake) begin
        wake_cause <= cause;
        if (dev_rst) rst_seen <= 1'b1;
        if (need_ost) begin
          state <= S_OST;
          cnt   <= CW'(OST_CYC - 1);
        end else begin
          state <= S_WDLY;
          cnt   <= CW'(WAKE_DLY - 1);
          if (src[0]) osc_stable <= 1'b1;
        end
      end else begin
        case (state)
          S_RUN: if (sleep_req) begin
            src <= sel_src;
            if (!idle_en) begin
              state      <= S_SLEEP;
              osc_stable <= 1'b0;
            end else begin
              state <= S_IDLE;
              if (!sel_src[0]) osc_stable <= 1'b0;
            end
          end
          S_OST: if (cnt == '0) begin
            if (pri_pll) begin
              state <= S_PLL;
              cnt   <= CW'(PLL_CYC - 1);
            end else begin
              state      <= S_WDLY;
              cnt        <= CW'(WAKE_DLY - 1);
              osc_stable <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
          S_PLL: if (cnt == '0) begin
            state      <= S_WDLY;
            cnt        <= CW'(WAKE_DLY - 1);
            osc_stable <= 1'b1;
          end else cnt <= cnt - 1'b1;
          S_WDLY: if (cnt == '0) begin
            state      <= S_RUN;
            pc_restart <= rst_seen;
            rst_seen   <= 1'b0;
          end else cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_pend,
  input logic       wdt_tmo,
  input logic       dev_rst,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic [2:0] clk_src,
  input logic       osc_stable,
  input logic       cpu_ready,
  input logic [1:0] wake_cause,
  input logic       pc_restart,
  input logic [2:0] st
);
  localparam logic [2:0] ST_IDLE = 3'd1;

  // R2
  clk_src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clk_src));

  // R1
  cpu_needs_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);

  // R8
  cause_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cause != 2'b00 && !dev_rst) |=> (wake_cause == 2'b00));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !int_pend && !wdt_tmo && !dev_rst)
      |=> (st == ST_IDLE && $stable(clk_src) && $stable(osc_stable)));

  // R4
  wake_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cause != 2'b00) |-> !cpu_ready);

  // R9
  restart_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_restart |-> cpu_ready);
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_pwr_mode_chk (
  .clk(clk), .rst_n(rst_n), .int_pend(int_pend), .wdt_tmo(wdt_tmo),
  .dev_rst(dev_rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .clk_src(clk_src), .osc_stable(osc_stable), .cpu_ready(cpu_ready),
  .wake_cause(wake_cause), .pc_restart(pc_restart), .st(state)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int LAT_FAST = 2;
  localparam int LAT_OST  = 1024 + 2;
  localparam int LAT_PLL  = 1024 + 64 + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, idle_en = 0, sosc_en = 0, pri_xtal = 0, pri_pll = 0;
  logic int_pend = 0, wdt_tmo = 0, dev_rst = 0;
  logic [1:0] clk_sel = 2'b00;
  logic cpu_clk_en, per_clk_en, osc_stable, cpu_ready, pc_restart;
  logic [2:0] clk_src;
  logic [1:0] wake_cause;

  always #2 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en),
    .clk_sel(clk_sel), .sosc_en(sosc_en), .pri_xtal(pri_xtal), .pri_pll(pri_pll),
    .int_pend(int_pend), .wdt_tmo(wdt_tmo), .dev_rst(dev_rst),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .clk_src(clk_src),
    .osc_stable(osc_stable), .cpu_ready(cpu_ready), .wake_cause(wake_cause),
    .pc_restart(pc_restart)
  );

  typedef struct packed {
    logic [1:0]  cause;
    logic [2:0]  src;
    logic        osc;
    logic        pcr;
    logic [15:0] lat;
    logic [7:0]  req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: times each wake and compares against the queue
  initial begin
    bit trk = 0;
    int lat = 0;
    logic [1:0] got = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!trk && wake_cause != 2'b00) begin
          trk = 1; lat = 0; got = wake_cause;
        end else if (trk) begin
          lat++;
          if (cpu_ready) begin
            trk = 0;
            if (q.size() == 0) begin
              chk("R8 unexpected wake", 1, 0);
            end else begin
              e = q.pop_front();
              chk($sformatf("R8 cause R%0d", e.req), got, e.cause);
              chk($sformatf("R4 latency R%0d", e.req), lat, e.lat);
              chk("R4 resume source", clk_src, e.src);
              chk("R4 cpu clock on", cpu_clk_en, 1);
              chk($sformatf("R6 osc_stable R%0d", e.req), osc_stable, e.osc);
              chk("R9 pc_restart", pc_restart, e.pcr);
            end
          end
        end
      end
    end
  end

  task automatic enter(input logic ie, input logic [1:0] sel, input logic se);
    @(negedge clk);
    idle_en = ie; clk_sel = sel; sosc_en = se; sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
  endtask

  task automatic wake_on(input logic i, input logic w, input logic r, input exp_t e);
    q.push_back(e);
    @(negedge clk);
    int_pend = i; wdt_tmo = w; dev_rst = r;
    @(negedge clk);
    int_pend = 0; wdt_tmo = 0; dev_rst = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk("R10 cpu_clk_en", cpu_clk_en, 1);
    chk("R10 per_clk_en", per_clk_en, 1);
    chk("R10 clk_src", clk_src, 3'b001);
    chk("R10 osc_stable", osc_stable, 1);
    chk("R10 cpu_ready", cpu_ready, 1);
    chk("R10 wake_cause", wake_cause, 0);
    chk("R10 pc_restart", pc_restart, 0);

    // R1 primary idle, crystal primary still skips start-up (R7)
    pri_xtal = 1;
    enter(1, 2'b00, 0);
    chk("R1 idle cpu_clk_en", cpu_clk_en, 0);
    chk("R1 idle per_clk_en", per_clk_en, 1);
    chk("R2 primary", clk_src, 3'b001);
    chk("R6 primary idle keeps osc", osc_stable, 1);
    // R3 a second sleep request in idle is ignored
    @(negedge clk); sleep_req = 1; idle_en = 0;
    @(negedge clk); sleep_req = 0;
    repeat (3) @(negedge clk);
    chk("R3 still idle per_clk_en", per_clk_en, 1);
    chk("R3 still idle cpu_ready", cpu_ready, 0);
    chk("R3 still idle clk_src", clk_src, 3'b001);
    wake_on(1, 0, 0, '{2'b01, 3'b001, 1'b1, 1'b0, 16'(LAT_FAST), 8'd7});

    // R2 secondary idle, watchdog wake
    enter(1, 2'b01, 1);
    chk("R2 secondary", clk_src, 3'b010);
    chk("R6 secondary clears osc", osc_stable, 0);
    wake_on(0, 1, 0, '{2'b10, 3'b010, 1'b0, 1'b0, 16'(LAT_FAST), 8'd4});

    // R2 low bit ignored; R8 watchdog beats interrupt
    enter(1, 2'b11, 1);
    chk("R2 internal sel 11", clk_src, 3'b100);
    wake_on(1, 1, 0, '{2'b10, 3'b100, 1'b0, 1'b0, 16'(LAT_FAST), 8'd8});

    // R5 fallback when secondary not enabled
    enter(1, 2'b01, 0);
    chk("R5 fallback keeps internal", clk_src, 3'b100);
    chk("R5 idle per_clk_en", per_clk_en, 1);
    wake_on(1, 0, 0, '{2'b01, 3'b100, 1'b0, 1'b0, 16'(LAT_FAST), 8'd5});

    // R7 primary idle entered from internal run needs start-up
    enter(1, 2'b00, 0);
    chk("R6 primary idle from internal osc", osc_stable, 0);
    wake_on(1, 0, 0, '{2'b01, 3'b001, 1'b1, 1'b0, 16'(LAT_OST), 8'd7});

    // R1 sleep, crystal primary
    enter(0, 2'b00, 0);
    chk("R1 sleep cpu_clk_en", cpu_clk_en, 0);
    chk("R1 sleep per_clk_en", per_clk_en, 0);
    chk("R1 sleep clk_src", clk_src, 3'b000);
    chk("R6 sleep clears osc", osc_stable, 0);
    wake_on(1, 0, 0, '{2'b01, 3'b001, 1'b1, 1'b0, 16'(LAT_OST), 8'd7});

    // R7 sleep, non-crystal primary
    pri_xtal = 0;
    enter(0, 2'b00, 0);
    chk("R6 sleep clears osc", osc_stable, 0);
    wake_on(0, 1, 0, '{2'b10, 3'b001, 1'b1, 1'b0, 16'(LAT_FAST), 8'd7});

    // R7 sleep, crystal with PLL
    pri_xtal = 1; pri_pll = 1;
    enter(0, 2'b00, 0);
    wake_on(1, 0, 0, '{2'b01, 3'b001, 1'b1, 1'b0, 16'(LAT_PLL), 8'd7});
    pri_pll = 0;

    // R9 reset from idle beats the other sources
    enter(1, 2'b10, 0);
    chk("R2 internal sel 10", clk_src, 3'b100);
    wake_on(1, 1, 1, '{2'b11, 3'b100, 1'b0, 1'b1, 16'(LAT_FAST), 8'd9});

    // R9 reset while running
    wake_on(0, 0, 1, '{2'b11, 3'b100, 1'b0, 1'b1, 16'(LAT_FAST), 8'd9});
    @(negedge clk);
    chk("R9 pc_restart one cycle", pc_restart, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule